// File: doc/BRIEF.md
# Chroma Multiplex Format Converter

This block takes a multiplexed digital chroma stream and turns it into separate U and V samples that are held at the full pixel rate. Two bus formats are accepted. In byte mode, U and V alternate sample by sample on the full chroma bus. In nibble mode, only the low half of the bus carries data, and each byte is split into a high half and a low half, so four pixel clocks carry one U/V pair.

Each sample is marked by a valid strobe. A line-start pulse restarts the multiplex phase, so the first sample of a video line is always taken as U. The incoming code may be binary offset or two's complement. A configuration input selects which. The outputs are always two's complement, because a binary-offset sample has its most significant bit inverted. U and V keep their last values between completed pairs. A valid flag reports whether a full pair has been built since the last line start.

Top module: `chroma_fmt_conv`

## Requirements
- R1: During and right after reset, u_out and v_out are zero and out_valid is low.
- R2: With nibble_mode=0, the first valid sample after a line start is U and the next valid sample is V. The pair appears on u_out/v_out after the clock edge that accepts the V sample.
- R3: With nibble_mode=1, four valid samples carry U high nibble, U low nibble, V high nibble and V low nibble, in that order. Each byte is rebuilt as {high, low}, and the pair appears after the edge that accepts the fourth sample.
- R4: With nibble_mode=1, chroma_in[7:4] is ignored. Only chroma_in[3:0] contributes to the result.
- R5: A line_start pulse resets the phase. A sample accepted in the same cycle as line_start is U, and this holds even when a pair was only partly received.
- R6: With offset_sel=1, bit 7 of each rebuilt U and V byte is inverted. With offset_sel=0, the bytes pass through unchanged.
- R7: u_out and v_out change only when a pair completes. Cycles without pix_valid, and partial pairs, leave them unchanged.
- R8: out_valid goes low on the edge after line_start and stays low until a pair completes. It then stays high until the next line_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chroma_in | input | 8 | Multiplexed chroma bus |
| pix_valid | input | 1 | A sample is present on chroma_in this cycle |
| line_start | input | 1 | Start of a video line; restarts the U/V phase |
| nibble_mode | input | 1 | 0: byte-wise U/V; 1: nibble-wise on bits 3:0 |
| offset_sel | input | 1 | 1: input is binary offset; 0: two's complement |
| u_out | output | 8 | Held U sample, two's complement |
| v_out | output | 8 | Held V sample, two's complement |
| out_valid | output | 1 | A complete pair has been produced since the last line start |

## Verification
A line start and an accepted sample can fall in the same cycle. The design must then clear the valid flag and also take that sample as U. The bench provokes this case in two ways. It starts every table vector with line_start and pix_valid high together. It also issues a second line start in the middle of a byte-mode pair, so the half-received U is replaced. The bench judges the result by the U/V values that appear after the later completion, and by out_valid staying low until that completion.

// File: rtl/chroma_fmt_pkg.sv
package chroma_fmt_pkg;
   // position inside one multiplexed U/V group
   typedef enum logic [1:0] {
      PH_A = 2'd0,
      PH_B = 2'd1,
      PH_C = 2'd2,
      PH_D = 2'd3
   } phase_e;
endpackage

// File: rtl/chroma_phase_ctr.sv
module chroma_phase_ctr
   import chroma_fmt_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pix_valid,
   input  logic   line_start,
   input  logic   nibble_mode,
   output phase_e ph_q,
   output phase_e ph_eff,
   output logic   pair_done
);
   phase_e     last_ph;
   logic [1:0] ph_inc;

   // a line start forces the current sample to the first slot
   assign ph_eff    = line_start ? PH_A : ph_q;
   assign last_ph   = nibble_mode ? PH_D : PH_B;
   assign pair_done = pix_valid && (ph_eff == last_ph);
   assign ph_inc    = ph_eff + 2'd1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= PH_A;
      end else if (pix_valid) begin
         ph_q <= (ph_eff == last_ph) ? PH_A : phase_e'(ph_inc);
      end else if (line_start) begin
         ph_q <= PH_A;
      end
   end
endmodule

// File: rtl/chroma_pair_asm.sv
module chroma_pair_asm
   import chroma_fmt_pkg::*;
#(
   parameter int SAMPLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pix_valid,
   input  logic                nibble_mode,
   input  phase_e              ph_eff,
   input  logic [SAMPLE_W-1:0] bus,
   output logic [SAMPLE_W-1:0] u_word,
   output logic [SAMPLE_W-1:0] v_word
);
   localparam int HALF_W = SAMPLE_W / 2;

   logic [SAMPLE_W-1:0] u_raw;
   logic [HALF_W-1:0]   v_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         u_raw <= '0;
         v_hi  <= '0;
      end else if (pix_valid) begin
         if (nibble_mode) begin
            unique case (ph_eff)
               PH_A:    u_raw[SAMPLE_W-1:HALF_W] <= bus[HALF_W-1:0];
               PH_B:    u_raw[HALF_W-1:0]        <= bus[HALF_W-1:0];
               PH_C:    v_hi                     <= bus[HALF_W-1:0];
               default: ;
            endcase
         end else if (ph_eff == PH_A) begin
            u_raw <= bus;
         end
      end
   end

   // V completes in the current cycle, so it is taken straight off the bus
   assign u_word = u_raw;
   assign v_word = nibble_mode ? {v_hi, bus[HALF_W-1:0]} : bus;
endmodule

// File: rtl/chroma_code_conv.sv
module chroma_code_conv #(
   parameter int SAMPLE_W     = 8,
   parameter bit ALLOW_OFFSET = 1'b1
) (
   input  logic [SAMPLE_W-1:0] raw,
   input  logic                offset_sel,
   output logic [SAMPLE_W-1:0] twos
);
   generate
      if (ALLOW_OFFSET) begin : g_conv
         // binary offset -> two's complement: flip the sign bit
         assign twos = {raw[SAMPLE_W-1] ^ offset_sel, raw[SAMPLE_W-2:0]};
      end else begin : g_pass
         logic unused_sel;
         assign unused_sel = offset_sel;
         assign twos       = raw;
      end
   endgenerate
endmodule

// File: rtl/chroma_out_stage.sv
module chroma_out_stage #(
   parameter int SAMPLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pair_done,
   input  logic                line_start,
   input  logic [SAMPLE_W-1:0] u_in,
   input  logic [SAMPLE_W-1:0] v_in,
   output logic [SAMPLE_W-1:0] u_out,
   output logic [SAMPLE_W-1:0] v_out,
   output logic                out_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         u_out     <= '0;
         v_out     <= '0;
         out_valid <= 1'b0;
      end else begin
         if (pair_done) begin
            u_out <= u_in;
            v_out <= v_in;
         end
         if (line_start)     out_valid <= 1'b0;
         else if (pair_done) out_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/chroma_fmt_conv.sv
module chroma_fmt_conv
   import chroma_fmt_pkg::*;
#(
   parameter int SAMPLE_W     = 8,
   parameter bit ALLOW_OFFSET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] chroma_in,
   input  logic                pix_valid,
   input  logic                line_start,
   input  logic                nibble_mode,
   input  logic                offset_sel,
   output logic [SAMPLE_W-1:0] u_out,
   output logic [SAMPLE_W-1:0] v_out,
   output logic                out_valid
);
   generate
      if (SAMPLE_W < 4 || (SAMPLE_W % 2) != 0) begin : g_bad_width
         $error("chroma_fmt_conv: SAMPLE_W must be even and at least 4");
      end
   endgenerate

   phase_e              ph_q;
   phase_e              ph_eff;
   logic                pair_done;
   logic [SAMPLE_W-1:0] u_word, v_word, u_conv, v_conv;

   chroma_phase_ctr phase_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_valid  (pix_valid),
      .line_start (line_start),
      .nibble_mode(nibble_mode),
      .ph_q       (ph_q),
      .ph_eff     (ph_eff),
      .pair_done  (pair_done)
   );

   chroma_pair_asm #(.SAMPLE_W(SAMPLE_W)) asm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_valid  (pix_valid),
      .nibble_mode(nibble_mode),
      .ph_eff     (ph_eff),
      .bus        (chroma_in),
      .u_word     (u_word),
      .v_word     (v_word)
   );

   chroma_code_conv #(.SAMPLE_W(SAMPLE_W), .ALLOW_OFFSET(ALLOW_OFFSET)) conv_u_i (
      .raw       (u_word),
      .offset_sel(offset_sel),
      .twos      (u_conv)
   );

   chroma_code_conv #(.SAMPLE_W(SAMPLE_W), .ALLOW_OFFSET(ALLOW_OFFSET)) conv_v_i (
      .raw       (v_word),
      .offset_sel(offset_sel),
      .twos      (v_conv)
   );

   chroma_out_stage #(.SAMPLE_W(SAMPLE_W)) out_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair_done (pair_done),
      .line_start(line_start),
      .u_in      (u_conv),
      .v_in      (v_conv),
      .u_out     (u_out),
      .v_out     (v_out),
      .out_valid (out_valid)
   );
endmodule

// File: rtl/chroma_fmt_conv_chk.sv
module chroma_fmt_conv_chk #(
   parameter int SAMPLE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pix_valid,
   input logic                line_start,
   input logic [SAMPLE_W-1:0] u_out,
   input logic [SAMPLE_W-1:0] v_out,
   input logic                out_valid,
   input logic [1:0]          ph
);
   // R8: a line start drops the valid flag on the next edge
   assert_valid_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> !out_valid);

   // R8: once valid, the flag stays until the next line start
   assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !line_start) |=> out_valid);

   // R8: valid only rises after an accepted sample
   assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(pix_valid));

   // R7: no accepted sample, no change of the held pair
   assert_hold_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ($stable(u_out) && $stable(v_out)));

   // R5: a lone line start parks the phase at the U slot
   assert_phase_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !pix_valid) |=> (ph == 2'd0));
endmodule

bind chroma_fmt_conv chroma_fmt_conv_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_valid (pix_valid),
   .line_start(line_start),
   .u_out     (u_out),
   .v_out     (v_out),
   .out_valid (out_valid),
   .ph        (ph_q)
);

// File: tb/chroma_fmt_conv_tb_top.sv
`timescale 1ns/100ps
module chroma_fmt_conv_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] chroma_in = '0;
   logic       pix_valid = 1'b0;
   logic       line_start = 1'b0;
   logic       nibble_mode = 1'b0;
   logic       offset_sel = 1'b0;
   logic [7:0] u_out, v_out;
   logic       out_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   chroma_fmt_conv dut_i (
      .clk(clk), .rst_n(rst_n), .chroma_in(chroma_in), .pix_valid(pix_valid),
      .line_start(line_start), .nibble_mode(nibble_mode), .offset_sel(offset_sel),
      .u_out(u_out), .v_out(v_out), .out_valid(out_valid)
   );

   // {nibble, offset, s0, s1, s2, s3, exp_u, exp_v}
   localparam int NVEC = 6;
   localparam logic [49:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'h12, 8'h34, 8'h00, 8'h00, 8'h12, 8'h34},
      {1'b0, 1'b1, 8'h80, 8'h7F, 8'h00, 8'h00, 8'h00, 8'hFF},
      {1'b1, 1'b0, 8'hA5, 8'h3C, 8'hF0, 8'h09, 8'h5C, 8'h09},
      {1'b1, 1'b1, 8'h01, 8'h02, 8'h0F, 8'h0E, 8'h92, 8'h7E},
      {1'b0, 1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h80, 8'h7F},
      {1'b1, 1'b0, 8'hF7, 8'hF8, 8'hE1, 8'hD2, 8'h78, 8'h12}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic ls, input logic vld, input logic [7:0] d);
      @(negedge clk);
      line_start = ls;
      pix_valid  = vld;
      chroma_in  = d;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 8'h00);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R1 u_out in reset", u_out, 8'h00);
      check("R1 v_out in reset", v_out, 8'h00);
      check("R1 out_valid in reset", {7'd0, out_valid}, 8'h00);
      rst_n = 1'b1;
      idle();
      check("R1 out_valid after reset", {7'd0, out_valid}, 8'h00);

      // table walk: R2, R3, R4, R6, R8; each vector opens with line_start+valid
      for (int i = 0; i < NVEC; i++) begin
         logic [49:0] e;
         int n;
         e = VEC[i];
         nibble_mode = e[49];
         offset_sel  = e[48];
         n = e[49] ? 4 : 2;
         drive(1'b1, 1'b1, e[47:40]);
         idle();
         check("R8 valid low after line start", {7'd0, out_valid}, 8'h00);
         drive(1'b0, 1'b1, e[39:32]);
         if (n == 4) begin
            drive(1'b0, 1'b1, e[31:24]);
            drive(1'b0, 1'b1, e[23:16]);
         end
         idle();
         check(e[49] ? "R3/R4/R6 u_out" : "R2/R6 u_out", u_out, e[15:8]);
         check(e[49] ? "R3/R4/R6 v_out" : "R2/R6 v_out", v_out, e[7:0]);
         check("R8 valid after pair", {7'd0, out_valid}, 8'h01);
      end

      // R5: restart in the middle of a byte pair
      nibble_mode = 1'b0;
      offset_sel  = 1'b0;
      drive(1'b1, 1'b1, 8'h11);
      drive(1'b1, 1'b1, 8'h22);
      drive(1'b0, 1'b1, 8'h33);
      idle();
      check("R5 u_out after mid-pair restart", u_out, 8'h22);
      check("R5 v_out after mid-pair restart", v_out, 8'h33);

      // R7: nibble pair with gaps; outputs hold until the fourth nibble
      nibble_mode = 1'b1;
      drive(1'b1, 1'b1, 8'h04);
      idle();
      idle();
      drive(1'b0, 1'b1, 8'h05);
      idle();
      check("R7 u_out held during partial pair", u_out, 8'h22);
      check("R7 v_out held during partial pair", v_out, 8'h33);
      check("R8 valid low during partial pair", {7'd0, out_valid}, 8'h00);
      drive(1'b0, 1'b1, 8'h06);
      idle();
      drive(1'b0, 1'b1, 8'h07);
      idle();
      check("R7 u_out after gapped pair", u_out, 8'h45);
      check("R7 v_out after gapped pair", v_out, 8'h67);

      // R8: lone line start clears valid, keeps data
      drive(1'b1, 1'b0, 8'hFF);
      idle();
      check("R8 valid cleared by lone line start", {7'd0, out_valid}, 8'h00);
      check("R7 u_out kept over line start", u_out, 8'h45);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule